// File: doc/BRIEF.md
# Byte-Wide Many-Time-Programmable Memory Model

This block is a cycle-level, synthesizable model of a small nonvolatile byte array that sits behind a classic EPROM-style pin set. It has active-low chip select and output gate pins, an address bus and an 8-bit data input. Two level flags stand in for the high-voltage conditions: one for the programming supply pin and one for address bit 9. The model decodes these pins into read, output disable, standby, byte program, whole-array erase, program/erase inhibit and identification. All pins are sampled on the rising clock edge.

A write can only clear bits. A program pulse ANDs the latched data into one byte. Only a whole-array erase sets bits back to 1. A program or erase pulse is the run of consecutive clock cycles with chip select low that starts in a high-voltage write mode. The operation and its operands are latched in the first cycle of the pulse. The operation is committed on the edge where chip select is seen high again, and only if the pulse lasted at least the parameterised minimum. A pulse that is too short leaves the array as it was and sets a sticky error flag. The output bus carries zero whenever the output-enable flag, which models the tri-state condition, is low.

Top module: `mtp_byte_mem`

## Requirements
- R1: `dout_en` is 1 only while `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and no pulse is in progress. Whenever `dout_en` is 0, `dout` is 8'h00.
- R2: With `a9_hi`=0 and `dout_en`=1, `dout` equals the byte stored at `addr`.
- R3: With `a9_hi`=1 and `dout_en`=1, `dout` is `MFG_ID` (8'hBF) at address 0, `DEV_ID` (8'hA4) at address 1, and 8'h00 at every other address.
- R4: After reset every byte reads 8'hFF and `pulse_err` is 0.
- R5: A pulse begins on a rising edge where the model is idle with `ce_n`=0, `vpp_hi`=1 and `oe_n`=1. If `a9_hi`=0 in that first cycle, the pulse is a program. If it spans at least `PROG_MIN` edges, the byte at the latched address becomes its old value ANDed with the latched data, on the first edge that samples `ce_n`=1.
- R6: If `a9_hi`=1 in the first cycle, the pulse is an erase. If it spans at least `ERASE_MIN` edges, every byte becomes 8'hFF when the pulse ends.
- R7: A pulse shorter than its minimum leaves every byte unchanged and sets `pulse_err`. The flag stays at 1 until reset.
- R8: With `ce_n`=1 nothing starts. With `vpp_hi`=1 and `oe_n`=0 (inhibit), no pulse starts and no data is driven.
- R9: Changes of `addr`, `din` and `a9_hi` after the first cycle of a pulse do not change what the pulse does.
- R10: While a pulse is in progress `dout_en` stays 0, even under read conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on rising edge |
| rst_n | input | 1 | Active-low reset, fills array with 8'hFF |
| addr | input | AW | Byte address |
| din | input | 8 | Data to program |
| ce_n | input | 1 | Active-low chip select, also the pulse pin |
| oe_n | input | 1 | Active-low output gate |
| vpp_hi | input | 1 | High voltage present on programming supply |
| a9_hi | input | 1 | High voltage present on address bit 9 |
| dout | output | 8 | Read data, zero when not driven |
| dout_en | output | 1 | Output driven (low models high impedance) |
| pulse_err | output | 1 | Sticky flag for a too-short pulse |

## Verification
The edge that ends a pulse and commits it is also the cycle in which the bench moves `addr`, `din` and `a9_hi` to new values. Some pulses also drop the supply flag and pull `oe_n` low right after the first cycle, which would otherwise mean a read. The bench judges the result by reading back both the latched target and the address it moved to, against a reference array. It also checks that no data appears while the pulse is open. Pulse lengths straddle each minimum by a few cycles, so the commit and the error decision meet on the same edge.

// File: rtl/mtp_byte_mem.sv
module mtp_byte_mem #(
  parameter int AW        = 8,
  parameter int PROG_MIN  = 20,
  parameter int ERASE_MIN = 100,
  parameter logic [7:0] MFG_ID = 8'hBF,
  parameter logic [7:0] DEV_ID = 8'hA4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          vpp_hi,
  input  logic          a9_hi,
  output logic [7:0]    dout,
  output logic          dout_en,
  output logic          pulse_err
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(ERASE_MIN + 1);

  logic [7:0]    mem [DEPTH];
  logic          busy, op_erase;
  logic [CW-1:0] cnt;
  logic [AW-1:0] lat_addr;
  logic [7:0]    lat_data;

  wire           start  = !busy && !ce_n && vpp_hi && oe_n;
  wire           finish = busy && ce_n;
  wire [CW-1:0]  need   = op_erase ? CW'(ERASE_MIN) : CW'(PROG_MIN);
  wire           enough = cnt >= need;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      op_erase  <= 1'b0;
      cnt       <= '0;
      lat_addr  <= '0;
      lat_data  <= '0;
      pulse_err <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (start) begin
      busy     <= 1'b1;
      op_erase <= a9_hi;
      cnt      <= CW'(1);
      lat_addr <= addr;
      lat_data <= din;
    end else if (finish) begin
      busy <= 1'b0;
      if (!enough) pulse_err <= 1'b1;
      else if (op_erase) for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      else mem[lat_addr] <= mem[lat_addr] & lat_data;
    end else if (busy && cnt < CW'(ERASE_MIN)) begin
      cnt <= cnt + CW'(1);
    end
  end

  wire [7:0] id_byte = (addr == '0)     ? MFG_ID :
                       (addr == AW'(1)) ? DEV_ID : 8'h00;

  assign dout_en = !ce_n && !oe_n && !vpp_hi && !busy;
  assign dout    = !dout_en ? 8'h00 : (a9_hi ? id_byte : mem[addr]);
endmodule

module mtp_byte_mem_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic vpp_hi,
  input logic dout_en,
  input logic busy,
  input logic pulse_err
);
  p_out_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!ce_n && !oe_n));
  p_start_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!ce_n && vpp_hi && oe_n));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_err |=> pulse_err);
  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_err) |-> $past(busy && ce_n));
  p_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !busy) |=> !busy);
  p_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && oe_n == 1'b0) |=> !busy);
  p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dout_en);
endmodule

bind mtp_byte_mem mtp_byte_mem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
  .dout_en(dout_en), .busy(busy), .pulse_err(pulse_err)
);

// File: tb/mtp_byte_mem_tb.sv
`timescale 1ns/1ps
module mtp_byte_mem_tb;
  localparam int AW = 8, PROG_MIN = 20, ERASE_MIN = 100, DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic ce_n = 1, oe_n = 1, vpp_hi = 0, a9_hi = 0, dout_en, pulse_err;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_mem [DEPTH];
  logic exp_err;

  always #5 clk = ~clk;

  mtp_byte_mem #(.AW(AW), .PROG_MIN(PROG_MIN), .ERASE_MIN(ERASE_MIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n), .oe_n(oe_n),
    .vpp_hi(vpp_hi), .a9_hi(a9_hi), .dout(dout), .dout_en(dout_en), .pulse_err(pulse_err));

  function automatic logic [7:0] exp_byte(input logic [AW-1:0] a, input logic id);
    if (!id) return exp_mem[a];
    if (a == 0) return 8'hBF;
    if (a == 1) return 8'hA4;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ce_n = 1; oe_n = 1; vpp_hi = 0; a9_hi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
    exp_err = 0;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic id);
    @(negedge clk); ce_n = 0; oe_n = 0; vpp_hi = 0; a9_hi = id; addr = a;
    #2;
    chk(req, dout_en, 1);
    chk(req, dout, exp_byte(a, id));
  endtask

  task automatic pulse(input logic [AW-1:0] a, input logic [7:0] d, input logic er,
                       input int n, input bit disturb);
    @(negedge clk); ce_n = 1; oe_n = 1;
    @(negedge clk); addr = a; din = d; a9_hi = er; vpp_hi = 1; ce_n = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (disturb && i == 0) begin
        addr = ~a; din = ~d; a9_hi = ~er; vpp_hi = 0; oe_n = 0;
        #2; chk("R10 busy read", dout_en, 0);
      end
    end
    ce_n = 1; oe_n = 1; addr = a + AW'(1); din = 8'h00; a9_hi = ~er;
    @(negedge clk); vpp_hi = 0; a9_hi = 0;
    if (n < (er ? ERASE_MIN : PROG_MIN)) exp_err = 1;
    else if (er) for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
    else exp_mem[a] = exp_mem[a] & d;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    #2;
    chk("R4 err", pulse_err, 0);
    chk("R1 idle", dout_en, 0);
    chk("R1 idle data", dout, 0);
    rd("R4 low", 0, 0);
    rd("R4 high", AW'(DEPTH - 1), 0);
    rd("R3 mfg", 0, 1);
    rd("R3 dev", 1, 1);
    rd("R3 other", 7, 1);
    @(negedge clk); oe_n = 1; #2;
    chk("R1 oe high", dout_en, 0);
    chk("R1 oe high data", dout, 0);

    pulse(3, 8'hF0, 0, PROG_MIN, 0);
    rd("R5 exact min", 3, 0);
    pulse(3, 8'h3C, 0, PROG_MIN + 4, 1);
    rd("R5 and", 3, 0);
    rd("R9 moved addr", ~AW'(3), 0);
    rd("R9 next addr", 4, 0);
    chk("R7 no err yet", pulse_err, 0);
    pulse(4, 8'h00, 0, PROG_MIN - 1, 0);
    rd("R7 short prog", 4, 0);
    chk("R7 err set", pulse_err, 1);

    @(negedge clk); ce_n = 0; oe_n = 0; vpp_hi = 1; addr = 5; din = 8'h00;
    #2; chk("R8 inhibit out", dout_en, 0);
    repeat (PROG_MIN + 2) @(negedge clk);
    ce_n = 1; oe_n = 1;
    @(negedge clk); addr = 6; din = 8'h00; ce_n = 1; oe_n = 1;
    repeat (PROG_MIN + 2) @(negedge clk);
    vpp_hi = 0;
    rd("R8 inhibit", 5, 0);
    rd("R8 standby", 6, 0);

    for (int k = 0; k < 60; k++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(DEPTH - 1, 0));
      pulse(a, 8'($urandom), 0, $urandom_range(PROG_MIN + 3, PROG_MIN - 2), bit'($urandom_range(1, 0)));
    end
    for (int k = 0; k < 40; k++) rd("R2 random", AW'($urandom_range(DEPTH - 1, 0)), 0);
    chk("R7 err model", pulse_err, exp_err);

    pulse(9, 8'h00, 1, ERASE_MIN - 1, 0);
    for (int k = 0; k < 8; k++) rd("R7 short erase", AW'(k * 31), 0);
    pulse(9, 8'h00, 1, ERASE_MIN, 1);
    for (int k = 0; k < DEPTH; k++) rd("R6 erased", AW'(k), 0);
    chk("R7 sticky", pulse_err, 1);

    do_reset();
    #2;
    chk("R4 err cleared", pulse_err, 0);
    rd("R4 after reset", 3, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule